// File: doc/BRIEF.md
# Special Character Detector

This block watches the receive data path of a serial port. Each received character is compared against one programmed special character. The comparison uses only the data bits that the configured word length makes active. When the detector is armed and a clean character matches, a sticky flag is raised for the interrupt logic. The character itself is never removed from the stream: matched or not, every character is handed on unchanged, one clock later, toward the receive FIFO.

The detector is armed only when its own enable is set and the software flow-control field is all zero, because the two features are mutually exclusive. Characters flagged with a framing or parity error still travel through the data path but never raise the flag. The host clears the flag with a one-cycle pulse, typically issued when it reads the interrupt status.

Top module: `spchar_detect`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0 and `spc_flag` is 0.
- R2: A character presented with `rx_valid`=1 appears on `out_data` with `out_valid`=1 exactly one clock later, unchanged, whether or not it matches.
- R3: A cycle with `rx_valid`=0 gives `out_valid`=0 one clock later.
- R4: Only the low N bits take part in the match, where N = 5 + `wlen` (`wlen` 0→5, 1→6, 2→7, 3→8 bits), with bit 0 as the least significant bit. Differences in bits at or above N are ignored.
- R5: A matching, error-free valid character sets `spc_flag` when `det_en`=1 and `fc_mode`=0. The flag becomes visible in the same cycle that the character appears on `out_valid`.
- R6: With `det_en`=0, no character sets `spc_flag`.
- R7: With `fc_mode` not equal to 0, no character sets `spc_flag`.
- R8: A character with `rx_frame_err`=1 or `rx_par_err`=1 never sets `spc_flag`, but it still passes through as in R2.
- R9: Once set, `spc_flag` stays set until `flag_clr` is asserted. Later matching or non-matching characters leave it set.
- R10: A `flag_clr` pulse clears `spc_flag` one clock later. If a setting match arrives in the same cycle as the clear, the flag is set one clock later.
- R11: A matching value on `rx_data` while `rx_valid`=0 does not set `spc_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_en | input | 1 | Detection enable |
| fc_mode | input | 4 | Software flow-control field; must be zero for detection |
| wlen | input | 2 | Word length code, N = 5 + wlen data bits |
| spc_char | input | 8 | Programmed special character |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Received character has a framing error |
| rx_par_err | input | 1 | Received character has a parity error |
| flag_clr | input | 1 | Clear pulse for the detection flag |
| out_valid | output | 1 | Pass-through character strobe |
| out_data | output | 8 | Pass-through character |
| spc_flag | output | 1 | Sticky special-character detection flag |

## Verification
The hardest case to reach is a clear pulse and a setting match that land in the same cycle. Because the flag is sticky, a bench that only watches it rise cannot tell whether set or clear won. The stimulus therefore first sets the flag, then drives `flag_clr` together with a matching valid character and checks that the flag is still high. It then repeats the clear pulse alone and checks that the flag drops. Masked upper bits are reached with a full sweep of every received value under every word length, so each pattern that differs only above bit N is covered.

// File: rtl/spchar_pkg.sv
package spchar_pkg;

    localparam int unsigned SPC_DATA_W = 8;
    localparam int unsigned SPC_MIN_W  = 5;
    localparam int unsigned SPC_WL_W   = 2;
    localparam int unsigned SPC_FC_W   = 4;

    typedef enum logic [SPC_WL_W-1:0] {
        WL_FIVE  = 2'd0,
        WL_SIX   = 2'd1,
        WL_SEVEN = 2'd2,
        WL_EIGHT = 2'd3
    } wlen_e;

endpackage

// File: rtl/spchar_cmp.sv
module spchar_cmp #(
    parameter int unsigned DATA_W = spchar_pkg::SPC_DATA_W,
    parameter int unsigned MIN_W  = spchar_pkg::SPC_MIN_W,
    parameter int unsigned WL_W   = spchar_pkg::SPC_WL_W
) (
    input  logic [WL_W-1:0]   wlen,
    input  logic [DATA_W-1:0] ref_char,
    input  logic [DATA_W-1:0] cand_char,
    output logic              hit
);
    localparam int unsigned TOP_W = MIN_W + (1 << WL_W) - 1;

    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] diff;

    // one enable per bit position: active when below 5 + wlen
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        if (gi < MIN_W) begin : g_always
            assign bit_mask[gi] = 1'b1;
        end else if (gi < TOP_W) begin : g_sel
            assign bit_mask[gi] = (32'(gi) < (32'(MIN_W) + 32'(wlen)));
        end else begin : g_never
            assign bit_mask[gi] = 1'b0;
        end
    end

    assign diff = (ref_char ^ cand_char) & bit_mask;
    assign hit  = (diff == '0);

    always_comb begin
        if (!$isunknown(wlen)) begin
            assert_mask_width_R4 : assert ($countones(bit_mask) == int'(MIN_W) + int'(wlen))
                else $error("mask width mismatch");
        end
    end
endmodule

// File: rtl/spchar_qual.sv
module spchar_qual #(
    parameter int unsigned FC_W = spchar_pkg::SPC_FC_W
) (
    input  logic            rx_valid,
    input  logic            det_en,
    input  logic [FC_W-1:0] fc_mode,
    input  logic            frame_err,
    input  logic            par_err,
    input  logic            hit,
    output logic            set_req
);
    logic armed;
    logic clean;

    assign armed   = det_en && (fc_mode == '0);
    assign clean   = !(frame_err || par_err);
    assign set_req = rx_valid && armed && clean && hit;
endmodule

// File: rtl/spchar_detect.sv
module spchar_detect #(
    parameter int unsigned DATA_W = spchar_pkg::SPC_DATA_W,
    parameter int unsigned MIN_W  = spchar_pkg::SPC_MIN_W,
    parameter int unsigned WL_W   = spchar_pkg::SPC_WL_W,
    parameter int unsigned FC_W   = spchar_pkg::SPC_FC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_en,
    input  logic [FC_W-1:0]   fc_mode,
    input  logic [WL_W-1:0]   wlen,
    input  logic [DATA_W-1:0] spc_char,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_frame_err,
    input  logic              rx_par_err,
    input  logic              flag_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              spc_flag
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              flag;
    } det_state_t;

    det_state_t st_d;
    det_state_t st_q;

    logic hit;
    logic set_req;

    spchar_cmp #(
        .DATA_W (DATA_W),
        .MIN_W  (MIN_W),
        .WL_W   (WL_W)
    ) u_cmp (
        .wlen      (wlen),
        .ref_char  (spc_char),
        .cand_char (rx_data),
        .hit       (hit)
    );

    spchar_qual #(
        .FC_W (FC_W)
    ) u_qual (
        .rx_valid  (rx_valid),
        .det_en    (det_en),
        .fc_mode   (fc_mode),
        .frame_err (rx_frame_err),
        .par_err   (rx_par_err),
        .hit       (hit),
        .set_req   (set_req)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = rx_valid;
        if (rx_valid) begin
            st_d.data = rx_data;
        end
        if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        if (set_req) begin
            st_d.flag = 1'b1;   // a fresh match outranks a clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign spc_flag  = st_q.flag;

    assert_pass_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (out_valid && out_data == $past(rx_data)))
        else $error("pass-through broken");

    assert_idle_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !out_valid)
        else $error("spurious out_valid");

    assert_rise_gate_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spc_flag) |-> ($past(rx_valid) && $past(det_en) && ($past(fc_mode) == '0)
                             && !$past(rx_frame_err) && !$past(rx_par_err)))
        else $error("flag rose without qualified match");

    assert_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (spc_flag && !flag_clr) |=> spc_flag)
        else $error("flag dropped without clear");

    assert_clear_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !rx_valid) |=> !spc_flag)
        else $error("clear ignored");
endmodule

// File: tb/spchar_detect_bench.sv
module spchar_detect_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_en = 1'b0;
    logic [3:0] fc_mode = 4'd0;
    logic [1:0] wlen = 2'd0;
    logic [7:0] spc_char = 8'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       rx_frame_err = 1'b0;
    logic       rx_par_err = 1'b0;
    logic       flag_clr = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       spc_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    spchar_detect u_spchar_detect (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .fc_mode(fc_mode), .wlen(wlen),
        .spc_char(spc_char), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .flag_clr(flag_clr),
        .out_valid(out_valid), .out_data(out_data), .spc_flag(spc_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_match(input logic [7:0] a, input logic [7:0] b, input logic [1:0] wl);
        int nb = 5 + int'(wl);
        return (((a ^ b) & 8'((1 << nb) - 1)) == 8'd0);
    endfunction

    // drive one character, check pass-through and flag on the following negedge
    task automatic send(input logic [7:0] d, input bit fe, input bit pe, input bit clr,
                        input bit exp_flag, input string req);
        rx_valid = 1'b1; rx_data = d; rx_frame_err = fe; rx_par_err = pe; flag_clr = clr;
        @(negedge clk);
        rx_valid = 1'b0; rx_frame_err = 1'b0; rx_par_err = 1'b0; flag_clr = 1'b0;
        chk(out_valid == 1'b1, "R2 out_valid", int'(out_valid), 1);
        chk(out_data == d, "R2 out_data", int'(out_data), int'(d));
        chk(spc_flag == exp_flag, req, int'(spc_flag), int'(exp_flag));
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(spc_flag == 1'b0, "R10 clear", int'(spc_flag), 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(out_data == 8'd0, "R1 out_data", int'(out_data), 0);
        chk(spc_flag == 1'b0, "R1 spc_flag", int'(spc_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R5 full sweep: every word length, two references, every value
        det_en = 1'b1; fc_mode = 4'd0;
        for (int wl = 0; wl < 4; wl++) begin
            for (int r = 0; r < 2; r++) begin
                wlen = 2'(wl);
                spc_char = (r == 0) ? 8'h13 : 8'hE5;
                for (int v = 0; v < 256; v++) begin
                    send(8'(v), 1'b0, 1'b0, 1'b0, is_match(8'(v), spc_char, 2'(wl)), "R4 R5 match");
                    if (spc_flag) clear_flag();
                end
            end
        end

        // R3 idle gives no out_valid
        @(negedge clk);
        chk(out_valid == 1'b0, "R3 idle", int'(out_valid), 0);

        wlen = 2'd3; spc_char = 8'hA7;
        // R6 disabled
        det_en = 1'b0;
        send(8'hA7, 1'b0, 1'b0, 1'b0, 1'b0, "R6 disabled");
        det_en = 1'b1;
        // R7 flow control field nonzero
        for (int f = 1; f < 16; f++) begin
            fc_mode = 4'(f);
            send(8'hA7, 1'b0, 1'b0, 1'b0, 1'b0, "R7 fc active");
        end
        fc_mode = 4'd0;
        // R8 errored characters still pass, no flag
        send(8'hA7, 1'b1, 1'b0, 1'b0, 1'b0, "R8 frame err");
        send(8'hA7, 1'b0, 1'b1, 1'b0, 1'b0, "R8 parity err");
        send(8'hA7, 1'b1, 1'b1, 1'b0, 1'b0, "R8 both err");
        // R11 match on data while not valid
        rx_data = 8'hA7;
        @(negedge clk);
        @(negedge clk);
        chk(spc_flag == 1'b0, "R11 invalid strobe", int'(spc_flag), 0);
        chk(out_valid == 1'b0, "R11 no out_valid", int'(out_valid), 0);

        // R9 sticky
        send(8'hA7, 1'b0, 1'b0, 1'b0, 1'b1, "R5 set");
        send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R9 sticky nonmatch");
        send(8'hA7, 1'b0, 1'b0, 1'b0, 1'b1, "R9 sticky rematch");
        repeat (5) @(negedge clk);
        chk(spc_flag == 1'b1, "R9 sticky idle", int'(spc_flag), 1);
        // R10 clear and match in same cycle: set wins
        send(8'hA7, 1'b0, 1'b0, 1'b1, 1'b1, "R10 set beats clear");
        clear_flag();
        // R10 clear with nonmatching char clears
        send(8'hA7, 1'b0, 1'b0, 1'b0, 1'b1, "R5 set again");
        send(8'h27, 1'b0, 1'b0, 1'b1, 1'b0, "R10 clear with nonmatch");

        finish_run();
    end
endmodule